// File: doc/BRIEF.md
# Colour LCD Controller Register and Interrupt Block

This block is the software-visible face of a simple colour LCD controller. It decodes a 4 KB register window, addressed by word, into four timing words, two frame base addresses, a control word and an interrupt mask. From the timing words it works out the active pixels per line and the active line count. From the control word it breaks out the pixel depth and the byte, pixel and colour ordering flags that the pixel pipeline uses. Pixel fetch and panel timing live elsewhere.

While the controller is both enabled and powered, a frame tick counter runs with a period set by a parameter. Each tick raises two interrupt status bits at once. Software reads raw or masked status and clears bits by writing ones. A level interrupt output stays high while any masked status bit is set. A strap input selects the layout variant: it exchanges the addresses of the mask and control words. A fixed block of eight identification bytes sits at the top of the window.

Top module: `lcdc_regblk`

## Requirements
- R1: After reset, every register reads zero, the read data output is zero and the interrupt output is low.
- R2: Word offsets 0 to 3 (timing words) and 4 and 5 (upper and lower base) read back what was last written. Word offsets 11 and 12 read the upper and lower base respectively.
- R3: The pixels per line output equals (timing 0 bits 7:2, plus 1) times 16.
- R4: The line count output equals timing 1 bits 9:0, plus 1.
- R5: With the variant strap low, word offset 6 is the interrupt mask and offset 7 is control. With the strap high the two are exchanged, for reads and writes alike.
- R6: Control bit 0 is enable, bits 3:1 pixel depth, bit 8 BGR order, bit 9 big-endian bytes, bit 10 big-endian pixels within a byte, bit 11 power. The controller is on only when bits 0 and 11 are both 1.
- R7: While the controller is on, status bits 2 and 3 are set together exactly FRAME_CYCLES cycles after the control write that turned it on, and every FRAME_CYCLES cycles after that. Any control write restarts the count.
- R8: While the controller is off, no frame tick occurs and status bits never become set.
- R9: Word offset 8 reads raw status (bits 3:0). Offset 9 reads raw status ANDed with the 4-bit mask. A write to offset 10 clears each status bit written as 1 and leaves the others alone.
- R10: The interrupt output is high exactly when raw status AND mask is non-zero, from the clock edge at which either of them changes.
- R11: Word offsets 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) return identification byte (offset - 0x3F8) of the ID_BYTES parameter, zero-extended; byte 0 is bits 7:0.
- R12: A read accepted at one clock edge presents its data from that edge onwards and holds it until the next read. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_swap | input | 1 | Variant strap: 1 exchanges mask and control offsets |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt |
| lcd_on | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel depth code from control |
| bgr_order | output | 1 | BGR colour order |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within a byte |
| cols_o | output | 11 | Active pixels per line |
| rows_o | output | 11 | Active lines |

## Verification
Geometry is driven with random timing words, including all-ones and all-zeros fields, so the bench can tell a dropped +1, a wrong shift or a wrong bit slice from correct decoding. The frame tick is tested with enable only, power only and both set; the test samples the interrupt in the cycle before and the cycle at the expected edge. This catches an off-by-one period and a tick that ignores either bit. The mask and clear are exercised with patterns that set one status bit but not the other, which separates raw from masked reads and shows whether the clear touches only the bits written as 1. The variant strap is flipped between reads, so a mux that swaps only writes or only reads shows up.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned STAT_W = 4;

  // word offsets in the register window
  localparam int unsigned OFF_TIM0   = 0;
  localparam int unsigned OFF_TIM3   = 3;
  localparam int unsigned OFF_UPBASE = 4;
  localparam int unsigned OFF_LOBASE = 5;
  localparam int unsigned OFF_SLOT_A = 6;
  localparam int unsigned OFF_SLOT_B = 7;
  localparam int unsigned OFF_RAW    = 8;
  localparam int unsigned OFF_MASKED = 9;
  localparam int unsigned OFF_CLEAR  = 10;
  localparam int unsigned OFF_CUR_UP = 11;
  localparam int unsigned OFF_CUR_LO = 12;

  // status bits raised by a frame tick
  localparam logic [STAT_W-1:0] TICK_BITS = 4'b1100;

  typedef struct packed {
    logic       power;
    logic       be_pix;
    logic       be_byte;
    logic       bgr;
    logic [2:0] depth;
    logic       enable;
  } ctrl_fields_t;

  function automatic ctrl_fields_t unpack_ctrl(input logic [WORD_W-1:0] w);
    ctrl_fields_t f;
    f.enable  = w[0];
    f.depth   = w[3:1];
    f.bgr     = w[8];
    f.be_byte = w[9];
    f.be_pix  = w[10];
    f.power   = w[11];
    return f;
  endfunction

endpackage

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_TIM  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swap,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [N_TIM-1:0][WORD_W-1:0] tim,
  output logic [WORD_W-1:0]           up_base,
  output logic [WORD_W-1:0]           lo_base,
  output logic [WORD_W-1:0]           ctrl,
  output logic [STAT_W-1:0]           mask,
  output logic                        ctrl_wr,
  output logic                        clr_wr
);

  logic hit_mask, hit_ctrl, hit_up, hit_lo;
  logic [WORD_W-1:0] up_nxt, lo_nxt, ctrl_nxt;
  logic [STAT_W-1:0] mask_nxt;

  always_comb begin
    hit_mask = wr_en && (wr_addr == ADDR_W'(swap ? OFF_SLOT_B : OFF_SLOT_A));
    hit_ctrl = wr_en && (wr_addr == ADDR_W'(swap ? OFF_SLOT_A : OFF_SLOT_B));
    hit_up   = wr_en && (wr_addr == ADDR_W'(OFF_UPBASE));
    hit_lo   = wr_en && (wr_addr == ADDR_W'(OFF_LOBASE));
    clr_wr   = wr_en && (wr_addr == ADDR_W'(OFF_CLEAR));
    ctrl_wr  = hit_ctrl;
    up_nxt   = hit_up   ? wr_data : up_base;
    lo_nxt   = hit_lo   ? wr_data : lo_base;
    ctrl_nxt = hit_ctrl ? wr_data : ctrl;
    mask_nxt = hit_mask ? wr_data[STAT_W-1:0] : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_base <= '0;
      lo_base <= '0;
      ctrl    <= '0;
      mask    <= '0;
    end else begin
      up_base <= up_nxt;
      lo_base <= lo_nxt;
      ctrl    <= ctrl_nxt;
      mask    <= mask_nxt;
    end
  end

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    logic              hit;
    logic [WORD_W-1:0] nxt;
    always_comb begin
      hit = wr_en && (wr_addr == ADDR_W'(OFF_TIM0 + g));
      nxt = hit ? wr_data : tim[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim[g] <= '0;
      else        tim[g] <= nxt;
    end
  end

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int unsigned PPL_W  = 6,
  parameter int unsigned LPP_W  = 10,
  parameter int unsigned COL_SH = 4,
  localparam int unsigned COL_W = PPL_W + 1 + COL_SH,
  localparam int unsigned ROW_W = LPP_W + 1
) (
  input  logic [PPL_W-1:0] ppl_field,
  input  logic [LPP_W-1:0] lpp_field,
  output logic [COL_W-1:0] cols,
  output logic [ROW_W-1:0] rows
);

  logic [PPL_W:0] col_units;

  always_comb begin
    col_units = {1'b0, ppl_field} + (PPL_W+1)'(1);
    cols      = {col_units, {COL_SH{1'b0}}};
    rows      = {1'b0, lpp_field} + ROW_W'(1);
  end

endmodule

// File: rtl/lcdc_frame_timer.sv
module lcdc_frame_timer #(
  parameter int unsigned FRAME_CYCLES = 64,
  localparam int unsigned CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             at_last;

  always_comb begin
    at_last = (cnt == LAST);
    tick    = run && !restart && at_last;
    if (restart || !run)  cnt_nxt = '0;
    else if (at_last)     cnt_nxt = '0;
    else                  cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq
  import lcdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] raw,
  output logic              irq
);

  logic [STAT_W-1:0] raw_nxt, kill, set;

  always_comb begin
    kill    = clr_en ? clr_bits : '0;
    set     = tick ? TICK_BITS : '0;
    raw_nxt = (raw & ~kill) | set;
    irq     = |(raw & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_nxt;
  end

endmodule

// File: rtl/lcdc_regblk.sv
module lcdc_regblk
  import lcdc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned FRAME_CYCLES = 64,
  parameter logic [63:0] ID_BYTES     = 64'hC3_5A_A5_3C_00_02_27_41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_swap,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              lcd_on,
  output logic [2:0]        pix_depth,
  output logic              bgr_order,
  output logic              be_bytes,
  output logic              be_pixels,
  output logic [10:0]       cols_o,
  output logic [10:0]       rows_o
);

  localparam int unsigned N_TIM   = 4;
  localparam int unsigned N_ID    = 8;
  localparam int unsigned ID_SEL  = $clog2(N_ID);
  localparam logic [ADDR_W-ID_SEL-1:0] ID_TOP = '1;

  logic [N_TIM-1:0][WORD_W-1:0] tim;
  logic [WORD_W-1:0] up_base, lo_base, ctrl;
  logic [STAT_W-1:0] mask, raw_stat;
  logic ctrl_wr, clr_wr, frame_tick, wr_fire, rd_fire;
  ctrl_fields_t cf;
  logic [WORD_W-1:0] rd_nxt, rd_word;

  assign wr_fire = bus_valid && bus_write;
  assign rd_fire = bus_valid && !bus_write;

  lcdc_regs #(.ADDR_W(ADDR_W), .N_TIM(N_TIM)) u_regs (
    .clk(clk), .rst_n(rst_n), .swap(cfg_swap), .wr_en(wr_fire),
    .wr_addr(bus_addr), .wr_data(bus_wdata), .tim(tim),
    .up_base(up_base), .lo_base(lo_base), .ctrl(ctrl), .mask(mask),
    .ctrl_wr(ctrl_wr), .clr_wr(clr_wr)
  );

  lcdc_geom #(.PPL_W(6), .LPP_W(10), .COL_SH(4)) u_geom (
    .ppl_field(tim[0][7:2]), .lpp_field(tim[1][9:0]),
    .cols(cols_o), .rows(rows_o)
  );

  always_comb begin
    cf        = unpack_ctrl(ctrl);
    lcd_on    = cf.enable && cf.power;
    pix_depth = cf.depth;
    bgr_order = cf.bgr;
    be_bytes  = cf.be_byte;
    be_pixels = cf.be_pix;
  end

  lcdc_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(lcd_on), .restart(ctrl_wr),
    .tick(frame_tick)
  );

  lcdc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .clr_en(clr_wr),
    .clr_bits(bus_wdata[STAT_W-1:0]), .mask(mask),
    .raw(raw_stat), .irq(irq_o)
  );

  // read decode
  always_comb begin
    rd_word = '0;
    if (bus_addr[ADDR_W-1:ID_SEL] == ID_TOP) begin
      rd_word = WORD_W'(ID_BYTES[bus_addr[ID_SEL-1:0]*8 +: 8]);
    end else begin
      case (bus_addr)
        ADDR_W'(OFF_TIM0), ADDR_W'(OFF_TIM0+1),
        ADDR_W'(OFF_TIM0+2), ADDR_W'(OFF_TIM3):
                                rd_word = tim[bus_addr[1:0]];
        ADDR_W'(OFF_UPBASE),
        ADDR_W'(OFF_CUR_UP):    rd_word = up_base;
        ADDR_W'(OFF_LOBASE),
        ADDR_W'(OFF_CUR_LO):    rd_word = lo_base;
        ADDR_W'(OFF_SLOT_A):    rd_word = cfg_swap ? ctrl : WORD_W'(mask);
        ADDR_W'(OFF_SLOT_B):    rd_word = cfg_swap ? WORD_W'(mask) : ctrl;
        ADDR_W'(OFF_RAW):       rd_word = WORD_W'(raw_stat);
        ADDR_W'(OFF_MASKED):    rd_word = WORD_W'(raw_stat & mask);
        default:                rd_word = '0;
      endcase
    end
    rd_nxt = rd_fire ? rd_word : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/lcdc_regblk_chk.sv
module lcdc_regblk_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              lcd_on,
  input logic [10:0]       rows_o,
  input logic [3:0]        raw_stat,
  input logic              frame_tick
);

  // R4: line count follows a timing 1 write
  assert_rows_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(1))
      |=> rows_o == {1'b0, $past(bus_wdata[9:0])} + 11'd1);

  // R7: a tick sets both status bits together
  assert_tick_sets_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> raw_stat[3:2] == 2'b11);

  // R8: no tick while off, and status cannot rise while off
  assert_no_tick_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> !frame_tick);
  assert_no_rise_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> !$rose(raw_stat[2]) && !$rose(raw_stat[3]));

  // R9: clearing both tick bits with no tick pending empties them
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(10) &&
     bus_wdata[3:2] == 2'b11 && !frame_tick) |=> raw_stat[3:2] == 2'b00);

  // R10: interrupt only with some status present
  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> raw_stat != 4'd0);

  // R12: unmapped read returns zero
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(13)) |=> bus_rdata == 32'd0);

endmodule

bind lcdc_regblk lcdc_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .lcd_on(lcd_on), .rows_o(rows_o),
  .raw_stat(raw_stat), .frame_tick(frame_tick)
);

// File: tb/sim_lcdc_regblk.sv
module sim_lcdc_regblk;

  localparam int unsigned AW = 10;
  localparam int unsigned P  = 64;
  localparam logic [63:0] IDV = 64'hC3_5A_A5_3C_00_02_27_41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_swap = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, lcd_on, bgr_order, be_bytes, be_pixels;
  logic [2:0] pix_depth;
  logic [10:0] cols_o, rows_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lcdc_regblk #(.ADDR_W(AW), .FRAME_CYCLES(P), .ID_BYTES(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .lcd_on(lcd_on),
    .pix_depth(pix_depth), .bgr_order(bgr_order), .be_bytes(be_bytes),
    .be_pixels(be_pixels), .cols_o(cols_o), .rows_o(rows_o)
  );

  function automatic logic [10:0] exp_cols(input logic [31:0] t0);
    return 11'((t0[7:2] + 32'd1) * 32'd16);
  endfunction

  function automatic logic [10:0] exp_rows(input logic [31:0] t1);
    return 11'(t1[9:0] + 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input int unsigned a, input logic [31:0] exp,
                        input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, req, v, exp);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [31:0] v, t0, t1, b;
    void'($urandom(32'd7305));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(bus_rdata === 32'd0, "R1 rdata", bus_rdata, 0);
    chk(irq_o === 1'b0, "R1 irq", 32'(irq_o), 0);
    for (int a = 0; a <= 12; a++) rd_chk(a, 32'd0, "R1 reg zero");
    chk(cols_o === 11'd16, "R3 reset cols", 32'(cols_o), 16);
    chk(rows_o === 11'd1, "R4 reset rows", 32'(rows_o), 1);

    // R2/R3/R4 random timing, base and readback
    for (int i = 0; i < 30; i++) begin
      t0 = $urandom(); t1 = $urandom();
      if (i == 0) begin t0 = 32'hFFFF_FFFF; t1 = 32'hFFFF_FFFF; end
      if (i == 1) begin t0 = 32'hFFFF_FF03; t1 = 32'hFFFF_FC00; end
      wr(0, t0); wr(1, t1);
      chk(cols_o === exp_cols(t0), "R3 cols", 32'(cols_o), 32'(exp_cols(t0)));
      chk(rows_o === exp_rows(t1), "R4 rows", 32'(rows_o), 32'(exp_rows(t1)));
      rd_chk(0, t0, "R2 timing0");
      b = $urandom(); wr(2 + (i % 2), b); rd_chk(2 + (i % 2), b, "R2 timing2/3");
      b = $urandom(); wr(4, b);
      rd_chk(4, b, "R2 upper base"); rd_chk(11, b, "R2 current upper");
      b = $urandom(); wr(5, b);
      rd_chk(5, b, "R2 lower base"); rd_chk(12, b, "R2 current lower");
    end

    // R6 control fields with the controller off
    for (int i = 0; i < 10; i++) begin
      v = $urandom();
      if (i % 2 == 0) v[0] = 1'b0; else v[11] = 1'b0;
      wr(7, v);
      chk(pix_depth === v[3:1], "R6 depth", 32'(pix_depth), 32'(v[3:1]));
      chk({be_pixels, be_bytes, bgr_order} === v[10:8], "R6 order flags",
          32'({be_pixels, be_bytes, bgr_order}), 32'(v[10:8]));
      chk(lcd_on === 1'b0, "R6 on needs both", 32'(lcd_on), 0);
      rd_chk(7, v, "R5 control at 7");
    end

    // R5 variant exchange
    wr(6, 32'h3);
    rd_chk(6, 32'h3, "R5 mask at 6");
    cfg_swap = 1'b1;
    wr(6, 32'h0000_0506);
    wr(7, 32'hFFFF_FFF5);
    rd_chk(6, 32'h0000_0506, "R5 swapped control at 6");
    rd_chk(7, 32'h5, "R5 swapped mask at 7");
    chk(pix_depth === 3'd3, "R5 swapped control write", 32'(pix_depth), 3);
    cfg_swap = 1'b0;
    rd_chk(7, 32'h0000_0506, "R5 control back at 7");
    rd_chk(6, 32'h5, "R5 mask back at 6");

    // R8 enable without power, power without enable
    wr(6, 32'hC);
    wr(7, 32'h0000_0001);
    repeat (2 * P) @(negedge clk);
    chk(irq_o === 1'b0, "R8 enable only", 32'(irq_o), 0);
    wr(7, 32'h0000_0800);
    repeat (2 * P) @(negedge clk);
    chk(irq_o === 1'b0, "R8 power only", 32'(irq_o), 0);
    rd_chk(8, 32'h0, "R8 raw stays clear");

    // R7/R10 tick period
    wr(7, 32'h0000_0801);
    chk(lcd_on === 1'b1, "R6 on", 32'(lcd_on), 1);
    repeat (P - 1) @(negedge clk);
    chk(irq_o === 1'b0, "R7 before first tick", 32'(irq_o), 0);
    @(negedge clk);
    chk(irq_o === 1'b1, "R7 first tick R10", 32'(irq_o), 1);
    wr(10, 32'hF);
    chk(irq_o === 1'b0, "R9 clear drops irq", 32'(irq_o), 0);
    repeat (P - 3) @(negedge clk);
    chk(irq_o === 1'b0, "R7 before second tick", 32'(irq_o), 0);
    @(negedge clk);
    chk(irq_o === 1'b1, "R7 second tick", 32'(irq_o), 1);

    // R9 raw vs masked, partial clear
    wr(7, 32'h0000_0001);
    rd_chk(8, 32'hC, "R9 raw both bits");
    wr(6, 32'h4);
    rd_chk(9, 32'h4, "R9 masked");
    wr(10, 32'h4);
    rd_chk(8, 32'h8, "R9 partial clear");
    chk(irq_o === 1'b0, "R10 unmasked bit only", 32'(irq_o), 0);
    wr(6, 32'h8);
    chk(irq_o === 1'b1, "R10 mask write raises irq", 32'(irq_o), 1);
    wr(10, 32'h8);
    chk(irq_o === 1'b0, "R10 clear lowers irq", 32'(irq_o), 0);

    // R11 identification bytes
    for (int i = 0; i < 8; i++)
      rd_chk(10'h3F8 + i, 32'(IDV[i*8 +: 8]), "R11 id byte");

    // R12 unmapped and read hold
    wr(13, 32'hDEAD_BEEF);
    wr(200, 32'h1234_5678);
    wr(10'h3F8, 32'hFFFF_FFFF);
    rd_chk(13, 32'h0, "R12 unmapped read");
    rd_chk(10'h3F8, 32'(IDV[7:0]), "R12 id write ignored");
    rd_chk(5, b, "R12 lower base untouched");
    repeat (3) @(negedge clk);
    chk(bus_rdata === b, "R12 read data held", bus_rdata, b);

    summary();
  end

endmodule